// File: doc/BRIEF.md
# Subvector Swizzle Move Unit

This block rebuilds one short subvector of up to four 32-bit single-precision elements in a new lane order. A 12-bit immediate holds one 3-bit selector per destination lane. Each selector either copies one of the source lanes, inserts the constant 0.0 or 1.0, or skips the lane. A skipped lane keeps its previous register value, because its write-enable stays low. The selectors therefore act as a lane reorder and an immediate write mask at the same time. Sources can be repeated, so a broadcast of one lane is a normal case.

A request is one `start` pulse. It carries the source subvector, the immediate, the subvector length minus one, and a single predicate bit that covers the whole subvector. One clock later the unit presents the new lanes, a per-lane write-enable and `out_valid`. There is no back-pressure: the consumer must accept each result in the cycle where `out_valid` is high. The result registers keep their value until the next request.

Top module: `swz_move_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `out_we` is 0 and `out_vec` is all zeros.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `start` was high, including back-to-back starts.
- R3: For a live lane k, selector bits [3k+2:3k] with code 0, 1, 2 or 3 copy source lane 0, 1, 2 or 3 (`src_vec` bits [32i+31:32i]) into output lane k with `out_we[k]`=1. A source lane may feed several destination lanes.
- R4: Code 4 writes 0x00000000 and code 5 writes 0x3F800000 into a live lane, with its write-enable set.
- R5: Codes 6 and 7 clear the lane's write-enable and drive its data to zero.
- R6: The length is `len_m1`+1. Lanes at or above that length have write-enable 0 and data 0, whatever their selector is.
- R7: When `pred` is 0, every write-enable is 0 and every output lane is zero.
- R8: A code from 0 to 3 that names a source lane at or above the length writes 0x00000000 with write-enable 1.
- R9: In cycles without `start`, `out_vec` and `out_we` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one subvector per high cycle |
| pred | input | 1 | Predicate bit for the whole subvector |
| len_m1 | input | 2 | Subvector length minus one |
| swz_imm | input | 12 | Three-bit selector per destination lane; lane 0 uses the low bits |
| src_vec | input | 128 | Source lanes, lane i in bits [32i+31:32i] |
| out_vec | output | 128 | Destination lanes, same layout as the source |
| out_we | output | 4 | Write-enable per destination lane |
| out_valid | output | 1 | Result strobe, one clock after `start` |

## Verification
The bench targets these corner cases:
- Length masking: a unit that ignores the length would write lanes past the end.
- Out-of-range source lanes: a unit that copies the raw source lane would leak stale data instead of zero.
- Skip codes 6 and 7: a unit that decodes only one of them, or sets its enable, would break the immediate write mask.
- Predicate off: a unit that gates data but not the enables would still write lanes.

Back-to-back starts and long idle gaps show whether `out_valid` is really a one-cycle echo of `start`, and whether the results hold between requests.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int unsigned SWZ_LANES  = 4;
  localparam int unsigned SWZ_ELEM_W = 32;
  localparam int unsigned SWZ_SEL_W  = 3;
  localparam logic [31:0] SWZ_FP_ZERO = 32'h0000_0000;
  localparam logic [31:0] SWZ_FP_ONE  = 32'h3F80_0000;
  // Code layout: 0..LANES-1 pick a source lane, then zero, one, then skip.
  localparam int unsigned SWZ_CODE_ZERO = SWZ_LANES;
  localparam int unsigned SWZ_CODE_ONE  = SWZ_LANES + 1;
endpackage

// File: rtl/swz_lane.sv
module swz_lane #(
  parameter int unsigned LANES  = swz_pkg::SWZ_LANES,
  parameter int unsigned ELEM_W = swz_pkg::SWZ_ELEM_W,
  parameter int unsigned SEL_W  = swz_pkg::SWZ_SEL_W,
  localparam int unsigned LEN_W = $clog2(LANES)
) (
  input  logic [LANES*ELEM_W-1:0] src_vec,
  input  logic [SEL_W-1:0]        sel,
  input  logic [LEN_W-1:0]        len_m1,
  input  logic                    live,
  output logic [ELEM_W-1:0]       data,
  output logic                    we
);
  localparam logic [SEL_W-1:0] C_ZERO = SEL_W'(swz_pkg::SWZ_CODE_ZERO);
  localparam logic [SEL_W-1:0] C_ONE  = SEL_W'(swz_pkg::SWZ_CODE_ONE);

  logic [SEL_W-1:0] len_ext;
  assign len_ext = {{(SEL_W-LEN_W){1'b0}}, len_m1};

  always_comb begin
    data = '0;
    we   = 1'b0;
    if (live) begin
      if (sel < SEL_W'(LANES)) begin
        we = 1'b1;
        if (sel <= len_ext) begin
          for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i)) data = src_vec[i*ELEM_W +: ELEM_W];
          end
        end else begin
          data = ELEM_W'(swz_pkg::SWZ_FP_ZERO);
        end
      end else if (sel == C_ZERO) begin
        we   = 1'b1;
        data = ELEM_W'(swz_pkg::SWZ_FP_ZERO);
      end else if (sel == C_ONE) begin
        we   = 1'b1;
        data = ELEM_W'(swz_pkg::SWZ_FP_ONE);
      end
    end
  end
endmodule

// File: rtl/swz_out_reg.sv
module swz_out_reg #(
  parameter int unsigned LANES  = swz_pkg::SWZ_LANES,
  parameter int unsigned ELEM_W = swz_pkg::SWZ_ELEM_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LANES*ELEM_W-1:0] nxt_vec,
  input  logic [LANES-1:0]        nxt_we,
  output logic [LANES*ELEM_W-1:0] q_vec,
  output logic [LANES-1:0]        q_we,
  output logic                    q_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vec   <= '0;
      q_we    <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_vec <= nxt_vec;
        q_we  <= nxt_we;
      end
    end
  end
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit #(
  parameter int unsigned LANES  = swz_pkg::SWZ_LANES,
  parameter int unsigned ELEM_W = swz_pkg::SWZ_ELEM_W,
  parameter int unsigned SEL_W  = swz_pkg::SWZ_SEL_W,
  localparam int unsigned LEN_W = $clog2(LANES),
  localparam int unsigned IMM_W = LANES*SEL_W,
  localparam int unsigned VEC_W = LANES*ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pred,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [IMM_W-1:0] swz_imm,
  input  logic [VEC_W-1:0] src_vec,
  output logic [VEC_W-1:0] out_vec,
  output logic [LANES-1:0] out_we,
  output logic             out_valid
);
  logic [VEC_W-1:0] nxt_vec;
  logic [LANES-1:0] nxt_we;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic live;
    assign live = pred && (LEN_W'(k) <= len_m1);
    swz_lane #(.LANES(LANES), .ELEM_W(ELEM_W), .SEL_W(SEL_W)) u_lane (
      .src_vec (src_vec),
      .sel     (swz_imm[k*SEL_W +: SEL_W]),
      .len_m1  (len_m1),
      .live    (live),
      .data    (nxt_vec[k*ELEM_W +: ELEM_W]),
      .we      (nxt_we[k])
    );
  end

  swz_out_reg #(.LANES(LANES), .ELEM_W(ELEM_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .nxt_vec (nxt_vec),
    .nxt_we  (nxt_we),
    .q_vec   (out_vec),
    .q_we    (out_we),
    .q_valid (out_valid)
  );
endmodule

// File: rtl/swz_move_unit_chk.sv
module swz_move_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         pred,
  input logic [1:0]   len_m1,
  input logic [11:0]  swz_imm,
  input logic [127:0] out_vec,
  input logic [3:0]   out_we,
  input logic         out_valid
);
  p_valid_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !out_valid);
  p_pred_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pred) |=> (out_we == 4'b0000 && out_vec == '0));
  p_len_one_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_m1 == 2'd0) |=> (out_we[3:1] == 3'b000));
  p_skip_lane0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && swz_imm[2:1] == 2'b11) |=> !out_we[0]);
  p_one_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pred && swz_imm[2:0] == 3'd5) |=> (out_vec[31:0] == 32'h3F80_0000 && out_we[0]));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && $past(rst_n)) |=> ($stable(out_vec) && $stable(out_we)));
endmodule

bind swz_move_unit swz_move_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pred(pred), .len_m1(len_m1),
  .swz_imm(swz_imm), .out_vec(out_vec), .out_we(out_we), .out_valid(out_valid)
);

// File: tb/test_swz_move_unit.sv
module test_swz_move_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         pred = 1'b0;
  logic [1:0]   len_m1 = 2'd0;
  logic [11:0]  swz_imm = '0;
  logic [127:0] src_vec = '0;
  logic [127:0] out_vec;
  logic [3:0]   out_we;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  logic [127:0] exp_vec = '0;
  logic [3:0]   exp_we = '0;
  logic         exp_valid = 1'b0;
  bit           cmp_on = 1'b0;

  always #10 clk = ~clk;

  swz_move_unit i_swz_move_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .pred(pred), .len_m1(len_m1),
    .swz_imm(swz_imm), .src_vec(src_vec), .out_vec(out_vec), .out_we(out_we),
    .out_valid(out_valid)
  );

  // Behavioural reference model, evaluated at every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_vec = '0; exp_we = '0; exp_valid = 1'b0;
    end else begin
      exp_valid = start;
      if (start) begin
        int len;
        len = int'(len_m1) + 1;
        for (int k = 0; k < 4; k++) begin
          int c;
          logic [31:0] v;
          logic w;
          c = int'(swz_imm[3*k +: 3]);
          v = 32'h0; w = 1'b0;
          if (pred && k < len) begin
            if (c < 4) begin
              w = 1'b1;
              v = (c < len) ? src_vec[32*c +: 32] : 32'h0;
            end else if (c == 4) begin
              w = 1'b1; v = 32'h0;
            end else if (c == 5) begin
              w = 1'b1; v = 32'h3F80_0000;
            end
          end
          exp_vec[32*k +: 32] = v;
          exp_we[k] = w;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      checks++;
      if (out_valid !== exp_valid) begin
        errors++;
        $display("FAIL %s/R2 out_valid actual %0b expected %0b", cur_req, out_valid, exp_valid);
      end
      checks++;
      if (out_we !== exp_we) begin
        errors++;
        $display("FAIL %s out_we actual %b expected %b", cur_req, out_we, exp_we);
      end
      checks++;
      if (out_vec !== exp_vec) begin
        errors++;
        $display("FAIL %s out_vec actual %h expected %h", cur_req, out_vec, exp_vec);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [11:0] mk(input int s0, input int s1, input int s2, input int s3);
    return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
  endfunction

  localparam logic [127:0] SRC_A = {32'h4040_0000, 32'h4000_0000, 32'hC0A0_0000, 32'h1234_5678};

  task automatic req(input logic p, input int len, input logic [11:0] imm,
                     input logic [127:0] src, input int gap);
    @(negedge clk);
    start = 1'b1; pred = p; len_m1 = 2'(len - 1); swz_imm = imm; src_vec = src;
    @(negedge clk);
    start = 1'b0; src_vec = ~src; swz_imm = ~imm;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    cmp_on = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R3"; req(1'b1, 4, mk(0,1,2,3), SRC_A, 1);
    req(1'b1, 4, mk(3,2,1,0), SRC_A, 1);
    req(1'b1, 4, mk(0,0,0,0), SRC_A, 1);
    cur_req = "R4"; req(1'b1, 4, mk(4,5,5,4), SRC_A, 1);
    cur_req = "R5"; req(1'b1, 4, mk(6,1,7,5), SRC_A, 1);
    cur_req = "R6"; req(1'b1, 1, mk(1,0,5,4), SRC_A, 1);
    req(1'b1, 3, mk(2,1,0,1), SRC_A, 1);
    cur_req = "R8"; req(1'b1, 2, mk(2,3,0,0), SRC_A, 1);
    cur_req = "R7"; req(1'b0, 4, mk(0,1,4,5), SRC_A, 1);
    cur_req = "R2";
    for (int n = 0; n < 6; n++) req(1'b1, 4, mk(n%6, (n+1)%6, (n+2)%8, 3), SRC_A ^ 128'(n), 0);
    cur_req = "R9"; req(1'b1, 4, mk(1,2,3,5), SRC_A, 8);
    cur_req = "R3";
    for (int n = 0; n < 300; n++)
      req(($urandom % 5) != 0, 1 + ($urandom % 4), 12'($urandom),
          {$urandom, $urandom, $urandom, $urandom}, $urandom % 2);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule